// File: doc/BRIEF.md
# Quad-Cell Slope Extraction Pipeline

This block turns a sparse stream of wavefront-sensor pixels into slope measurements. Each sub-aperture arrives as exactly four pixels of a 2x2 quad-cell, with no guard pixels between cells. Every pixel is first corrected with its own offset and gain. When the fourth pixel of a cell has been corrected, the block computes the normalised X and Y spot displacement. It emits them as one tagged record while the rest of the frame is still arriving.

Three things are loaded at run time: a per-pixel correction table, a per-cell enable mask and an intensity threshold. The mask picks the sub-apertures that the guide object lights, and this set changes as the guide object moves. Writes land in a staging copy. The copy in use is replaced only when a frame starts, so one frame is never processed with a mix of old and new settings. A cell whose corrected light is too weak gives zero slopes and a dark flag, so that noise is not passed on as a measurement.

Top module: `qc_slope_pipe`

## Requirements
- R1: After a synchronous active-low reset, `slope_valid` is low. The tables in use hold offset 0, gain 1.0, every cell enabled and threshold 0.
- R2: Each pixel is corrected as min(floor(max(pix - offset, 0) * gain / 2^GAIN_FRAC), 2^PIX_W - 1). The gain is unsigned with GAIN_FRAC fraction bits (4096 is 1.0 by default). Offset and gain are chosen per pixel, at address cell*4 + position.
- R3: Within a cell the pixels arrive in the order A (top-left), B (top-right), C (bottom-left), D (bottom-right). The position counter returns to A on `frame_start`. A cell lit only in B gives X = Y = +2^FRAC, and a cell lit only in C gives X = Y = -2^FRAC.
- R4: With corrected pixels A, B, C, D and total S = A+B+C+D, X = ((B+D)-(A+C))*2^FRAC/S and Y = ((A+B)-(C+D))*2^FRAC/S. The division truncates toward zero.
- R5: For an enabled cell, exactly one record carrying `slope_cell` appears. `slope_valid` goes high on the second rising edge after the edge that accepts the fourth pixel. This holds whether the pixels come back to back or with idle cycles between them.
- R6: The mask is written with bit 0 of the data (1 = enabled) at address = cell. A disabled cell produces no record.
- R7: If S is zero or S < threshold, the record has X = Y = 0 and `slope_dark` = 1. Otherwise `slope_dark` = 0. S equal to the threshold is not dark.
- R8: `cfg_sel` selects 0 = offset, 1 = gain, 2 = mask, 3 = threshold. Writes reach a staging copy that replaces the tables in use on `frame_start` only. Cells sent before that keep using the previous settings.
- R9: Both slopes always lie within -2^FRAC to +2^FRAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Frame boundary pulse: staging tables become active, position counter cleared |
| pix_valid | input | 1 | A pixel is present on `pix_data` |
| pix_data | input | PIX_W | Raw pixel intensity |
| pix_cell | input | CELL_W | Quad-cell index of the pixel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Table select: 0 offset, 1 gain, 2 mask, 3 threshold |
| cfg_addr | input | CELL_W+2 | Pixel entry (cell*4+position) or cell number for the mask |
| cfg_data | input | PIX_W | Value written |
| slope_valid | output | 1 | A slope record is present |
| slope_cell | output | CELL_W | Cell index of the record |
| slope_x | output | SLOPE_W | Signed X slope, FRAC fraction bits |
| slope_y | output | SLOPE_W | Signed Y slope, FRAC fraction bits |
| slope_dark | output | 1 | Cell too dim; slopes forced to zero |

## Verification
The assertions take the input stream to be well formed. `frame_start` never arrives in the same cycle as a pixel. Every cell is sent as four pixels that carry the same index. Reset is held long enough that the pipeline history it looks back on was idle. The stimulus drives whole cells only and places frame pulses and table writes on cycles without a pixel. It varies the spacing between pixels, so the fixed latency is checked under gaps as well as at full rate.

// File: rtl/qc_pkg.sv
// Shared definitions for the quad-cell slope pipeline.
package qc_pkg;
    // Table selector carried on cfg_sel.
    typedef enum logic [1:0] {
        CFG_OFFSET = 2'd0,
        CFG_GAIN   = 2'd1,
        CFG_MASK   = 2'd2,
        CFG_THRESH = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/qc_cfg_tables.sv
// Staging and active copies of the correction, mask and threshold tables.
// Writes go to staging only; 'swap' copies staging into active at a frame
// boundary. Assumes the number of cells is 2**CELL_W.
module qc_cfg_tables
    import qc_pkg::*;
#(
    parameter int CELL_W    = 4,
    parameter int PIX_W     = 16,
    parameter int GAIN_FRAC = 12
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                swap,
    input  logic                we,
    input  logic [1:0]          sel,
    input  logic [CELL_W+1:0]   addr,
    input  logic [PIX_W-1:0]    data,
    input  logic [CELL_W-1:0]   rd_cell,
    input  logic [1:0]          rd_pos,
    output logic [PIX_W-1:0]    rd_off,
    output logic [PIX_W-1:0]    rd_gain,
    output logic                rd_mask,
    output logic [PIX_W-1:0]    rd_thr
);
    localparam int N_CELLS = 1 << CELL_W;
    localparam int N_PIX   = N_CELLS * 4;
    localparam logic [PIX_W-1:0] GAIN_ONE = PIX_W'(1) << GAIN_FRAC;

    logic [PIX_W-1:0]   off_sh  [N_PIX];
    logic [PIX_W-1:0]   gain_sh [N_PIX];
    logic [PIX_W-1:0]   off_act [N_PIX];
    logic [PIX_W-1:0]   gain_act[N_PIX];
    logic [N_CELLS-1:0] mask_sh, mask_act;
    logic [PIX_W-1:0]   thr_sh, thr_act;

    // Staging copy: accepts configuration writes at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PIX; i++) begin
                off_sh[i]  <= '0;
                gain_sh[i] <= GAIN_ONE;
            end
            mask_sh <= '1;
            thr_sh  <= '0;
        end else if (we) begin
            unique case (cfg_sel_e'(sel))
                CFG_OFFSET: off_sh[addr]  <= data;
                CFG_GAIN:   gain_sh[addr] <= data;
                CFG_MASK:   mask_sh[addr[CELL_W-1:0]] <= data[0];
                CFG_THRESH: thr_sh <= data;
            endcase
        end
    end

    // Active per-pixel entries: one copy register pair per pixel.
    for (genvar g = 0; g < N_PIX; g++) begin : g_pix_bank
        // Load the staging entry on a frame boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_act[g]  <= '0;
                gain_act[g] <= GAIN_ONE;
            end else if (swap) begin
                off_act[g]  <= off_sh[g];
                gain_act[g] <= gain_sh[g];
            end
        end
    end

    // Active mask and threshold, swapped with the pixel entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_act <= '1;
            thr_act  <= '0;
        end else if (swap) begin
            mask_act <= mask_sh;
            thr_act  <= thr_sh;
        end
    end

    // Read port for the pixel currently entering the pipeline.
    always_comb begin
        rd_off  = off_act[{rd_cell, rd_pos}];
        rd_gain = gain_act[{rd_cell, rd_pos}];
        rd_mask = mask_act[rd_cell];
        rd_thr  = thr_act;
    end
endmodule

// File: rtl/qc_pix_correct.sv
// Stage 1: offset subtraction (clamped at zero), gain multiplication and
// saturation to the pixel width. Registers the corrected pixel together
// with the settings the later stages need, so a table swap cannot reach a
// pixel already accepted.
module qc_pix_correct #(
    parameter int CELL_W    = 4,
    parameter int PIX_W     = 16,
    parameter int GAIN_FRAC = 12
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [PIX_W-1:0]    in_pix,
    input  logic [1:0]          in_pos,
    input  logic [CELL_W-1:0]   in_cell,
    input  logic [PIX_W-1:0]    in_off,
    input  logic [PIX_W-1:0]    in_gain,
    input  logic                in_mask,
    input  logic [PIX_W-1:0]    in_thr,
    output logic                o_valid,
    output logic [PIX_W-1:0]    o_corr,
    output logic [1:0]          o_pos,
    output logic [CELL_W-1:0]   o_cell,
    output logic                o_mask,
    output logic [PIX_W-1:0]    o_thr
);
    logic [PIX_W:0]     diff;
    logic [PIX_W-1:0]   mag;
    logic [2*PIX_W-1:0] prod, scaled;
    logic [PIX_W-1:0]   corr;

    // Correction arithmetic for the incoming pixel.
    always_comb begin
        diff   = {1'b0, in_pix} - {1'b0, in_off};
        mag    = diff[PIX_W] ? '0 : diff[PIX_W-1:0];
        prod   = {{PIX_W{1'b0}}, mag} * {{PIX_W{1'b0}}, in_gain};
        scaled = prod >> GAIN_FRAC;
        corr   = (|scaled[2*PIX_W-1:PIX_W]) ? '1 : scaled[PIX_W-1:0];
    end

    // Valid flag of the stage.
    always_ff @(posedge clk) begin
        if (!rst_n) o_valid <= 1'b0;
        else        o_valid <= in_valid;
    end

    // Data registers, loaded only with a pixel.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            o_corr <= corr;
            o_pos  <= in_pos;
            o_cell <= in_cell;
            o_mask <= in_mask;
            o_thr  <= in_thr;
        end
    end
endmodule

// File: rtl/qc_cell_accum.sv
// Stage 2: holds pixels A, B and C of a cell; when D arrives forms the
// X and Y numerators, the total and the dark decision. Emits only for
// enabled cells. Assumes the four pixels of a cell arrive in order.
module qc_cell_accum #(
    parameter int CELL_W = 4,
    parameter int PIX_W  = 16
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [PIX_W-1:0]            in_corr,
    input  logic [1:0]                  in_pos,
    input  logic [CELL_W-1:0]           in_cell,
    input  logic                        in_mask,
    input  logic [PIX_W-1:0]            in_thr,
    output logic                        o_valid,
    output logic [CELL_W-1:0]           o_cell,
    output logic signed [PIX_W+1:0]     o_num_x,
    output logic signed [PIX_W+1:0]     o_num_y,
    output logic [PIX_W+1:0]            o_total,
    output logic                        o_dark
);
    localparam int SW = PIX_W + 2;

    logic [PIX_W-1:0] a_q, b_q, c_q;
    logic [SW-1:0]    ea, eb, ec, ed, total;
    logic signed [SW-1:0] nx, ny;
    logic             dark;

    // Sums and differences for the cell completing this cycle.
    always_comb begin
        ea    = SW'(a_q);
        eb    = SW'(b_q);
        ec    = SW'(c_q);
        ed    = SW'(in_corr);
        total = ea + eb + ec + ed;
        nx    = signed'(eb + ed) - signed'(ea + ec);
        ny    = signed'(ea + eb) - signed'(ec + ed);
        dark  = (total == '0) || (total < SW'(in_thr));
    end

    // Hold the first three pixels of the current cell.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            case (in_pos)
                2'd0:    a_q <= in_corr;
                2'd1:    b_q <= in_corr;
                2'd2:    c_q <= in_corr;
                default: ;
            endcase
        end
    end

    // Emit the cell summary on its fourth pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
        end else begin
            o_valid <= in_valid && (in_pos == 2'd3) && in_mask;
        end
        if (in_valid && in_pos == 2'd3) begin
            o_cell  <= in_cell;
            o_num_x <= nx;
            o_num_y <= ny;
            o_total <= total;
            o_dark  <= dark;
        end
    end
endmodule

// File: rtl/qc_slope_div.sv
// Stage 3: normalises both numerators by the cell total in fixed point
// with FRAC fraction bits (truncation toward zero), forcing zero for dark
// cells. Assumes |numerator| <= total, so results fit SLOPE_W.
module qc_slope_div #(
    parameter int CELL_W  = 4,
    parameter int PIX_W   = 16,
    parameter int FRAC    = 10,
    parameter int SLOPE_W = FRAC + 2
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [CELL_W-1:0]           in_cell,
    input  logic signed [PIX_W+1:0]     in_num_x,
    input  logic signed [PIX_W+1:0]     in_num_y,
    input  logic [PIX_W+1:0]            in_total,
    input  logic                        in_dark,
    output logic                        o_valid,
    output logic [CELL_W-1:0]           o_cell,
    output logic signed [SLOPE_W-1:0]   o_x,
    output logic signed [SLOPE_W-1:0]   o_y,
    output logic                        o_dark
);
    localparam int DW = PIX_W + 3 + FRAC;

    // Signed fixed-point ratio num / den.
    function automatic logic signed [SLOPE_W-1:0] ratio(
        input logic signed [PIX_W+1:0] num,
        input logic [PIX_W+1:0]        den
    );
        logic signed [DW-1:0] n, d, q;
        n = DW'(num) <<< FRAC;
        d = signed'(DW'(den));
        q = n / d;
        return q[SLOPE_W-1:0];
    endfunction

    logic [PIX_W+1:0]          den;
    logic signed [SLOPE_W-1:0] qx, qy;

    // Divide with a safe denominator; dark cells read zero.
    always_comb begin
        den = in_dark ? (PIX_W+2)'(1) : in_total;
        qx  = in_dark ? '0 : ratio(in_num_x, den);
        qy  = in_dark ? '0 : ratio(in_num_y, den);
    end

    // Output record register.
    always_ff @(posedge clk) begin
        if (!rst_n) o_valid <= 1'b0;
        else        o_valid <= in_valid;
        if (in_valid) begin
            o_cell <= in_cell;
            o_x    <= qx;
            o_y    <= qy;
            o_dark <= in_dark;
        end
    end
endmodule

// File: rtl/qc_slope_pipe.sv
// Top: quad-cell slope extraction. Tracks the pixel position inside each
// cell, reads the active tables for it and runs the three-stage pipeline.
// Assumes frame_start never coincides with pix_valid and that the four
// pixels of a cell carry the same index.
module qc_slope_pipe #(
    parameter int CELL_W    = 4,
    parameter int PIX_W     = 16,
    parameter int GAIN_FRAC = 12,
    parameter int FRAC      = 10,
    parameter int SLOPE_W   = FRAC + 2
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic                        pix_valid,
    input  logic [PIX_W-1:0]            pix_data,
    input  logic [CELL_W-1:0]           pix_cell,
    input  logic                        cfg_we,
    input  logic [1:0]                  cfg_sel,
    input  logic [CELL_W+1:0]           cfg_addr,
    input  logic [PIX_W-1:0]            cfg_data,
    output logic                        slope_valid,
    output logic [CELL_W-1:0]           slope_cell,
    output logic signed [SLOPE_W-1:0]   slope_x,
    output logic signed [SLOPE_W-1:0]   slope_y,
    output logic                        slope_dark
);
    logic [1:0]        pos_q;
    logic [PIX_W-1:0]  cur_off, cur_gain, cur_thr;
    logic              cur_mask;

    logic              s1_valid, s1_mask;
    logic [PIX_W-1:0]  s1_corr, s1_thr;
    logic [1:0]        s1_pos;
    logic [CELL_W-1:0] s1_cell;

    logic                    s2_valid, s2_dark;
    logic [CELL_W-1:0]       s2_cell;
    logic signed [PIX_W+1:0] s2_nx, s2_ny;
    logic [PIX_W+1:0]        s2_total;

    // Position of the next pixel within its cell.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) pos_q <= 2'd0;
        else if (pix_valid)        pos_q <= pos_q + 2'd1;
    end

    qc_cfg_tables #(.CELL_W(CELL_W), .PIX_W(PIX_W), .GAIN_FRAC(GAIN_FRAC)) u_tables (
        .clk(clk), .rst_n(rst_n), .swap(frame_start),
        .we(cfg_we), .sel(cfg_sel), .addr(cfg_addr), .data(cfg_data),
        .rd_cell(pix_cell), .rd_pos(pos_q),
        .rd_off(cur_off), .rd_gain(cur_gain), .rd_mask(cur_mask), .rd_thr(cur_thr)
    );

    qc_pix_correct #(.CELL_W(CELL_W), .PIX_W(PIX_W), .GAIN_FRAC(GAIN_FRAC)) u_correct (
        .clk(clk), .rst_n(rst_n),
        .in_valid(pix_valid), .in_pix(pix_data), .in_pos(pos_q), .in_cell(pix_cell),
        .in_off(cur_off), .in_gain(cur_gain), .in_mask(cur_mask), .in_thr(cur_thr),
        .o_valid(s1_valid), .o_corr(s1_corr), .o_pos(s1_pos), .o_cell(s1_cell),
        .o_mask(s1_mask), .o_thr(s1_thr)
    );

    qc_cell_accum #(.CELL_W(CELL_W), .PIX_W(PIX_W)) u_accum (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s1_valid), .in_corr(s1_corr), .in_pos(s1_pos), .in_cell(s1_cell),
        .in_mask(s1_mask), .in_thr(s1_thr),
        .o_valid(s2_valid), .o_cell(s2_cell), .o_num_x(s2_nx), .o_num_y(s2_ny),
        .o_total(s2_total), .o_dark(s2_dark)
    );

    qc_slope_div #(.CELL_W(CELL_W), .PIX_W(PIX_W), .FRAC(FRAC), .SLOPE_W(SLOPE_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s2_valid), .in_cell(s2_cell), .in_num_x(s2_nx), .in_num_y(s2_ny),
        .in_total(s2_total), .in_dark(s2_dark),
        .o_valid(slope_valid), .o_cell(slope_cell), .o_x(slope_x), .o_y(slope_y),
        .o_dark(slope_dark)
    );
endmodule

// File: rtl/qc_slope_pipe_chk.sv
// Checker for qc_slope_pipe: output timing, masking, dark forcing, slope
// range and the frame-boundary input rule. Bound to the top below.
module qc_slope_pipe_chk #(
    parameter int FRAC    = 10,
    parameter int SLOPE_W = FRAC + 2
)(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      frame_start,
    input logic                      pix_valid,
    input logic [1:0]                pos_q,
    input logic                      cur_mask,
    input logic                      slope_valid,
    input logic signed [SLOPE_W-1:0] slope_x,
    input logic signed [SLOPE_W-1:0] slope_y,
    input logic                      slope_dark
);
    localparam int LIM = 1 << FRAC;

    // R1: no record in the first cycle out of reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !slope_valid);

    // R5: an enabled cell's fourth pixel yields a record two edges later.
    a_r5_record_follows_cell: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pix_valid && pos_q == 2'd3 && cur_mask, 3) |-> slope_valid);

    // R6: a record only ever follows the fourth pixel of an enabled cell.
    a_r6_only_enabled_cells: assert property (@(posedge clk) disable iff (!rst_n)
        slope_valid |-> $past(pix_valid && pos_q == 2'd3 && cur_mask, 3));

    // R7: dark records carry zero slopes.
    a_r7_dark_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (slope_valid && slope_dark) |-> (slope_x == '0 && slope_y == '0));

    // R9: slopes stay within one full scale.
    a_r9_slope_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        slope_valid |-> ($signed(slope_x) <= LIM && $signed(slope_x) >= -LIM &&
                         $signed(slope_y) <= LIM && $signed(slope_y) >= -LIM));

    // R8: frame boundaries sit on cycles without a pixel (input rule).
    a_r8_frame_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !pix_valid);
endmodule

bind qc_slope_pipe qc_slope_pipe_chk #(.FRAC(FRAC), .SLOPE_W(SLOPE_W)) i_qc_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .pos_q(pos_q), .cur_mask(cur_mask), .slope_valid(slope_valid),
    .slope_x(slope_x), .slope_y(slope_y), .slope_dark(slope_dark)
);

// File: tb/test_qc_slope_pipe.sv
// Bench for qc_slope_pipe with 8 cells: sweeps cells, pixel positions,
// offsets, gains, masks and thresholds against an arithmetic model.
module test_qc_slope_pipe;
    localparam int CW = 3;
    localparam int NC = 8;
    localparam int NP = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic pix_valid = 1'b0;
    logic [15:0] pix_data = '0;
    logic [CW-1:0] pix_cell = '0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [CW+1:0] cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic slope_valid;
    logic [CW-1:0] slope_cell;
    logic signed [11:0] slope_x, slope_y;
    logic slope_dark;

    qc_slope_pipe #(.CELL_W(CW), .PIX_W(16), .GAIN_FRAC(12), .FRAC(10), .SLOPE_W(12)) i_qc_slope_pipe (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_cell(pix_cell),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .slope_valid(slope_valid), .slope_cell(slope_cell),
        .slope_x(slope_x), .slope_y(slope_y), .slope_dark(slope_dark)
    );

    always #2.5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Model of the configuration: staging and active copies.
    longint m_off_sh[NP], m_gain_sh[NP], m_off_act[NP], m_gain_act[NP];
    bit     m_mask_sh[NC], m_mask_act[NC];
    longint m_thr_sh, m_thr_act;

    // Captured and expected records.
    int ncap = 0, nexp = 0;
    int cap_cell[64], cap_x[64], cap_y[64], cap_dark[64];
    longint cap_cyc[64];
    int exp_cell[64], exp_x[64], exp_y[64], exp_dark[64];
    longint exp_cyc[64];

    always @(negedge clk) begin
        if (rst_n && slope_valid && ncap < 64) begin
            cap_cell[ncap] = int'(slope_cell);
            cap_x[ncap]    = int'($signed(slope_x));
            cap_y[ncap]    = int'($signed(slope_y));
            cap_dark[ncap] = int'(slope_dark);
            cap_cyc[ncap]  = cyc;
            ncap++;
        end
    end

    task automatic check(input bit ok, input string what, input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    function automatic longint corr(input longint p, input longint o, input longint g);
        longint d, v;
        d = p - o;
        if (d < 0) d = 0;
        v = (d * g) / 4096;
        if (v > 65535) v = 65535;
        return v;
    endfunction

    function automatic longint ratio(input longint n, input longint t);
        return (n * 1024) / t;
    endfunction

    task automatic idle();
        @(negedge clk);
        pix_valid = 0; cfg_we = 0; frame_start = 0;
    endtask

    task automatic cfg_write(input int sel, input int addr, input int data);
        @(negedge clk);
        pix_valid = 0; frame_start = 0;
        cfg_we = 1; cfg_sel = 2'(sel); cfg_addr = 5'(addr); cfg_data = 16'(data);
        case (sel)
            0: m_off_sh[addr] = data;
            1: m_gain_sh[addr] = data;
            2: m_mask_sh[addr] = data[0];
            default: m_thr_sh = data;
        endcase
    endtask

    task automatic frame();
        @(negedge clk);
        pix_valid = 0; cfg_we = 0; frame_start = 1;
        m_off_act = m_off_sh; m_gain_act = m_gain_sh;
        m_mask_act = m_mask_sh; m_thr_act = m_thr_sh;
    endtask

    task automatic set_all(input int off, input int gain);
        for (int p = 0; p < NP; p++) begin
            cfg_write(0, p, off);
            cfg_write(1, p, gain);
        end
    endtask

    task automatic send_cell(input int c, input int a, input int b, input int cc, input int d, input int gap);
        int v[4];
        longint k[4];
        longint tot, td;
        bit dk;
        v[0] = a; v[1] = b; v[2] = cc; v[3] = d;
        td = 0;
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            cfg_we = 0; frame_start = 0;
            pix_valid = 1; pix_data = 16'(v[p]); pix_cell = CW'(c);
            if (p == 3) td = cyc;
            k[p] = corr(v[p], m_off_act[c*4+p], m_gain_act[c*4+p]);
            for (int g = 0; g < gap; g++) idle();
        end
        tot = k[0] + k[1] + k[2] + k[3];
        dk = (tot == 0) || (tot < m_thr_act);
        if (m_mask_act[c] && nexp < 64) begin
            exp_cell[nexp] = c;
            exp_dark[nexp] = int'(dk);
            exp_x[nexp] = dk ? 0 : int'(ratio((k[1] + k[3]) - (k[0] + k[2]), tot));
            exp_y[nexp] = dk ? 0 : int'(ratio((k[0] + k[1]) - (k[2] + k[3]), tot));
            exp_cyc[nexp] = td + 3;
            nexp++;
        end
    endtask

    task automatic compare_all(input string tag);
        int n;
        repeat (6) idle();
        check(ncap == nexp, {tag, " record count"}, ncap, nexp);
        n = (ncap < nexp) ? ncap : nexp;
        for (int i = 0; i < n; i++) begin
            check(cap_cell[i] == exp_cell[i], {tag, " cell index"}, cap_cell[i], exp_cell[i]);
            check(cap_cyc[i] == exp_cyc[i], {tag, " R5 output cycle"}, cap_cyc[i], exp_cyc[i]);
            check(cap_x[i] == exp_x[i], {tag, " slope x"}, cap_x[i], exp_x[i]);
            check(cap_y[i] == exp_y[i], {tag, " slope y"}, cap_y[i], exp_y[i]);
            check(cap_dark[i] == exp_dark[i], {tag, " R7 dark flag"}, cap_dark[i], exp_dark[i]);
            check(cap_x[i] <= 1024 && cap_x[i] >= -1024, "R9 slope x range", cap_x[i], 1024);
        end
        ncap = 0;
        nexp = 0;
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_off_sh[p] = 0; m_gain_sh[p] = 4096;
        end
        for (int c = 0; c < NC; c++) m_mask_sh[c] = 1;
        m_thr_sh = 0;
        m_off_act = m_off_sh; m_gain_act = m_gain_sh;
        m_mask_act = m_mask_sh; m_thr_act = m_thr_sh;

        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(slope_valid == 0, "R1 valid low after reset", slope_valid, 0);
        idle(); idle();
        check(ncap == 0, "R1 no record while idle", ncap, 0);

        // R4 with reset-default tables (R1): varied patterns on all cells.
        frame();
        for (int c = 0; c < NC; c++)
            send_cell(c, 100 + 37*c, 900 - 50*c, 400 + 111*c, 20 + 300*c, 0);
        compare_all("R4");

        // R3 orientation: B only, then C only.
        frame();
        send_cell(2, 0, 1000, 0, 0, 0);
        send_cell(5, 0, 0, 800, 0, 0);
        repeat (6) idle();
        check(ncap == 2, "R3 orientation record count", ncap, 2);
        check(cap_x[0] == 1024 && cap_y[0] == 1024, "R3 B-only slope x", cap_x[0], 1024);
        check(cap_x[1] == -1024 && cap_y[1] == -1024, "R3 C-only slope x", cap_x[1], -1024);
        ncap = 0; nexp = 0;

        // R2 sweep: per-pixel offsets and gains, clamping and saturation.
        for (int f = 0; f < 6; f++) begin
            for (int p = 0; p < NP; p++) begin
                cfg_write(0, p, (f == 5) ? (40000 + p*100) : ((p*911 + f*503) % 3000));
                cfg_write(1, p, 4096 + ((f*1111 + p*313) % 12000));
            end
            frame();
            for (int c = 0; c < NC; c++)
                send_cell(c, (c*7919 + 0*4099 + f*12345 + 17) % 65536,
                             (c*7919 + 1*4099 + f*12345 + 17) % 65536,
                             (c*7919 + 2*4099 + f*12345 + 17) % 65536,
                             (c*7919 + 3*4099 + f*12345 + 17) % 65536, 0);
            compare_all("R2");
        end

        // R5 latency with idle gaps between pixels.
        set_all(50, 5000);
        frame();
        for (int c = 0; c < NC; c++)
            send_cell(c, 300 + c*90, 2000 - c*40, 700 + c*13, 1500 + c*200, c % 4);
        compare_all("R5");

        // R6 mask: odd cells disabled.
        for (int c = 1; c < NC; c += 2) cfg_write(2, c, 0);
        frame();
        for (int c = 0; c < NC; c++) send_cell(c, 500, 600 + c, 700, 800 - c, 0);
        compare_all("R6");
        for (int c = 0; c < NC; c++) cfg_write(2, c, 1);

        // R7 threshold: zero, below, equal and above.
        set_all(0, 4096);
        cfg_write(3, 0, 5000);
        frame();
        send_cell(0, 0, 0, 0, 0, 0);
        send_cell(1, 1000, 1000, 1000, 1000, 0);
        send_cell(2, 1250, 1250, 1250, 1250, 0);
        send_cell(3, 2000, 100, 100, 3000, 0);
        send_cell(4, 1249, 1250, 1250, 1250, 0);
        compare_all("R7");
        cfg_write(3, 0, 0);

        // R8 staging: mid-frame writes wait for the next frame boundary.
        set_all(0, 8192);
        frame();
        for (int c = 0; c < 4; c++) send_cell(c, 1000 + c, 1200, 900, 1100 - c, 0);
        for (int p = 16; p < NP; p++) cfg_write(1, p, 4096);
        cfg_write(2, 6, 0);
        for (int c = 4; c < NC; c++) send_cell(c, 30000, 1200 + c, 900, 1100, 0);
        compare_all("R8");
        frame();
        for (int c = 4; c < NC; c++) send_cell(c, 30000, 1200 + c, 900, 1100, 0);
        compare_all("R8");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule